// File: doc/BRIEF.md
# Descriptor ring fetch controller

This block walks two rings of descriptors in system memory on behalf of a crypto offload engine. Software writes the base address of a source ring and of a destination ring, fills descriptors, hands each one to the engine by setting its ownership bit, and then kicks the controller. The controller reads descriptors through a single-word memory port. It gathers the source descriptors of one request and passes each buffer to a datapath stub. It then closes the request on one destination descriptor and hands every processed descriptor back to software by clearing its ownership bit.

A request starts at a source descriptor carrying the first-segment flag. Every owned descriptor after it with that flag clear belongs to the same request. The request closes when the next source descriptor is either the first segment of a new request or not owned by the engine. Any descriptor may carry an end-of-ring flag, and the pointer then returns to the programmed base. Unavailable descriptors, bad lengths and completed requests are latched as pending status bits. These are cleared by writing 1, and each is gated by an enable bit to form one interrupt line.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` and `busy` are low and no memory request is made.
- R2: Register offsets: 0x0 source ring base, 0x4 destination ring base, 0x8 command/status, 0xC control. Control keeps bits 15:11 and 8:0 (reads 0 elsewhere). Bits 2:0 and 5:3 are the source and destination burst codes, bit 6 is clock enable, bit 7 is in-place write-back and bit 8 is loopback. Writing a base register also moves that ring's pointer to the new base.
- R3: Writing 1 to command bit 1 while control bit 6 is set starts a walk. With bit 6 clear the kick is ignored.
- R4: Word 0 bit 31 of a descriptor is ownership. The controller only consumes owned descriptors, and it writes word 0 back with bit 31 cleared and every other bit unchanged.
- R5: A source descriptor is four words: flags, length, unused, buffer address. Each accepted one is presented to the datapath with its address, its length and a first flag, which is set only for the first descriptor of a request. Flag bit 29 starts a request.
- R6: A request closes on exactly one destination descriptor of eight words. The controller waits for the datapath finish handshake, clears that descriptor's ownership and sets status bit 12.
- R7: After a descriptor with word 0 bit 30 set, that ring's pointer returns to its base. Otherwise the source pointer advances by 16 bytes and the destination pointer by 32 bytes.
- R8: An unowned source descriptor met outside a request sets status bit 15 and the controller goes idle.
- R9: A source length of 0 or above 8192 sets status bit 14, abandons the request, leaves that descriptor owned and idles. A length of 8192 is accepted.
- R10: An unowned destination descriptor at request close sets status bit 13 and idles. The next kick retries that close before any further source descriptor.
- R11: Status bits 15:11 are cleared by writing 1 to them at 0x8. `irq` is high when any pending bit has its enable set at the same position in control.
- R12: Writing 1 to command bit 0 clears all pending bits, abandons any partial request, returns both pointers to their bases and idles.
- R13: A finish handshake that comes with `dp_buf_flag` high sets status bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| dp_valid | output | 1 | Source buffer offered to the datapath |
| dp_first | output | 1 | Offered buffer opens a request |
| dp_addr | output | 32 | Offered buffer address |
| dp_len | output | 32 | Offered buffer length in bytes |
| dp_ready | input | 1 | Datapath accepts the offered buffer |
| dp_fin | output | 1 | Controller requests request completion |
| dp_fin_ack | input | 1 | Datapath acknowledges completion |
| dp_buf_flag | input | 1 | Data address buffer event with the acknowledge |
| irq | output | 1 | Interrupt |
| busy | output | 1 | Controller is walking the rings |

## Verification
The walk is driven with a two-descriptor request followed by a one-descriptor request. This separates grouping by the first-segment flag from closing on an unowned descriptor. Length values of 0, 8193 and exactly 8192 split the length check at both edges. An unowned destination followed by a second kick shows that the pending close resumes and no source descriptor is skipped. End-of-ring flags on both rings, and a soft reset in the middle of a ring, show whether the pointers return to base or advance by their strides. A behavioural model predicts every datapath transfer, the memory image and the status word.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  localparam int WORD_W  = 32;
  localparam int PEND_W  = 5;
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;
  localparam int FS_BIT  = 29;

  // Pending vector order (index -> status bit): 4->15, 3->14, 2->13, 1->12, 0->11
  localparam int P_SRC_UNAV = 4;
  localparam int P_SRC_LEN  = 3;
  localparam int P_DST_UNAV = 2;
  localparam int P_DST_DONE = 1;
  localparam int P_DABF     = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRC_W0,
    ST_SRC_LEN,
    ST_SRC_ADR,
    ST_SRC_DP,
    ST_SRC_CLR,
    ST_DST_W0,
    ST_DST_FIN,
    ST_DST_CLR
  } walk_state_e;

  function automatic logic [WORD_W-1:0] ring_next(input logic [WORD_W-1:0] ptr,
                                                  input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] stride,
                                                  input logic              eor);
    return eor ? base : ptr + stride;
  endfunction

  function automatic logic len_valid(input logic [WORD_W-1:0] len,
                                     input logic [WORD_W-1:0] max_len);
    return (len != '0) && (len <= max_len);
  endfunction

  function automatic logic [WORD_W-1:0] drop_own(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[OWN_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/rfc_ring_ptr.sv
module rfc_ring_ptr
  import rfc_pkg::*;
#(
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              advance,
  input  logic              eor,
  input  logic [WORD_W-1:0] base,
  output logic [WORD_W-1:0] ptr
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (advance) begin
      ptr <= ring_next(ptr, base, STEP, eor);
    end
  end

endmodule

// File: rtl/rfc_regs.sv
module rfc_regs
  import rfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [PEND_W-1:0] ev_set,
  output logic [WORD_W-1:0] src_base,
  output logic [WORD_W-1:0] dst_base,
  output logic              src_load,
  output logic [WORD_W-1:0] src_load_val,
  output logic              dst_load,
  output logic [WORD_W-1:0] dst_load_val,
  output logic              kick,
  output logic              sreset,
  output logic [PEND_W-1:0] pend,
  output logic              irq
);

  localparam logic [3:0] OFS_SRC = 4'h0;
  localparam logic [3:0] OFS_DST = 4'h4;
  localparam logic [3:0] OFS_CMD = 4'h8;
  localparam logic [3:0] OFS_CTL = 4'hC;
  localparam int         CKE_BIT = 6;

  logic              wr_src, wr_dst, wr_cmd, wr_ctl;
  logic [PEND_W-1:0] ctl_en;
  logic [8:0]        ctl_low;
  logic [PEND_W-1:0] w1c;

  assign wr_src = reg_we && (reg_addr == OFS_SRC);
  assign wr_dst = reg_we && (reg_addr == OFS_DST);
  assign wr_cmd = reg_we && (reg_addr == OFS_CMD);
  assign wr_ctl = reg_we && (reg_addr == OFS_CTL);

  assign sreset = wr_cmd && reg_wdata[0];
  assign kick   = wr_cmd && reg_wdata[1] && !reg_wdata[0] && ctl_low[CKE_BIT];
  assign w1c    = wr_cmd ? reg_wdata[15:11] : '0;

  assign src_load     = wr_src || sreset;
  assign src_load_val = wr_src ? reg_wdata : src_base;
  assign dst_load     = wr_dst || sreset;
  assign dst_load_val = wr_dst ? reg_wdata : dst_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      ctl_en   <= '0;
      ctl_low  <= '0;
    end else begin
      if (wr_src) src_base <= reg_wdata;
      if (wr_dst) dst_base <= reg_wdata;
      if (wr_ctl) begin
        ctl_en  <= reg_wdata[15:11];
        ctl_low <= reg_wdata[8:0];
      end
    end
  end

  // Events win over a same-cycle clear; soft reset wins over both.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (sreset) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~w1c) | ev_set;
    end
  end

  assign irq = |(pend & ctl_en);

  always_comb begin
    unique case (reg_addr)
      OFS_SRC: reg_rdata = src_base;
      OFS_DST: reg_rdata = dst_base;
      OFS_CMD: reg_rdata = {16'h0, pend, 11'h0};
      OFS_CTL: reg_rdata = {16'h0, ctl_en, 2'b00, ctl_low};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rfc_walker.sv
module rfc_walker
  import rfc_pkg::*;
#(
  parameter int MAX_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              sreset,
  input  logic [WORD_W-1:0] src_ptr,
  input  logic [WORD_W-1:0] dst_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dp_valid,
  output logic              dp_first,
  output logic [WORD_W-1:0] dp_addr,
  output logic [WORD_W-1:0] dp_len,
  input  logic              dp_ready,
  output logic              dp_fin,
  input  logic              dp_fin_ack,
  input  logic              dp_buf_flag,
  output logic              src_adv,
  output logic              src_eor,
  output logic              dst_adv,
  output logic              dst_eor,
  output logic [PEND_W-1:0] ev_set,
  output logic              busy
);

  localparam logic [WORD_W-1:0] LEN_OFS = WORD_W'(4);
  localparam logic [WORD_W-1:0] ADR_OFS = WORD_W'(12);
  localparam logic [WORD_W-1:0] LEN_MAX = WORD_W'(MAX_LEN);

  walk_state_e       state;
  logic [WORD_W-1:0] sw0, dw0, slen, sadr;
  logic              in_req, close_pend;
  logic              rd_own, rd_fs, rd_len_ok;

  assign rd_own    = mem_rdata[OWN_BIT];
  assign rd_fs     = mem_rdata[FS_BIT];
  assign rd_len_ok = len_valid(mem_rdata, LEN_MAX);

  assign busy = (state != ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = src_ptr;
    mem_wdata = '0;
    unique case (state)
      ST_SRC_W0:  mem_req = 1'b1;
      ST_SRC_LEN: begin mem_req = 1'b1; mem_addr = src_ptr + LEN_OFS; end
      ST_SRC_ADR: begin mem_req = 1'b1; mem_addr = src_ptr + ADR_OFS; end
      ST_SRC_CLR: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = drop_own(sw0); end
      ST_DST_W0:  begin mem_req = 1'b1; mem_addr = dst_ptr; end
      ST_DST_CLR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_ptr;
        mem_wdata = drop_own(dw0);
      end
      default: ;
    endcase
  end

  assign dp_valid = (state == ST_SRC_DP);
  assign dp_first = !in_req;
  assign dp_addr  = sadr;
  assign dp_len   = slen;
  assign dp_fin   = (state == ST_DST_FIN);

  assign src_adv = (state == ST_SRC_CLR) && mem_gnt;
  assign src_eor = sw0[EOR_BIT];
  assign dst_adv = (state == ST_DST_CLR) && mem_gnt;
  assign dst_eor = dw0[EOR_BIT];

  always_comb begin
    ev_set             = '0;
    ev_set[P_SRC_UNAV] = (state == ST_SRC_W0) && mem_gnt && !rd_own && !in_req;
    ev_set[P_SRC_LEN]  = (state == ST_SRC_LEN) && mem_gnt && !rd_len_ok;
    ev_set[P_DST_UNAV] = (state == ST_DST_W0) && mem_gnt && !rd_own;
    ev_set[P_DST_DONE] = (state == ST_DST_CLR) && mem_gnt;
    ev_set[P_DABF]     = (state == ST_DST_FIN) && dp_fin_ack && dp_buf_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sw0        <= '0;
      dw0        <= '0;
      slen       <= '0;
      sadr       <= '0;
      in_req     <= 1'b0;
      close_pend <= 1'b0;
    end else if (sreset) begin
      state      <= ST_IDLE;
      in_req     <= 1'b0;
      close_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (kick) state <= close_pend ? ST_DST_W0 : ST_SRC_W0;
        ST_SRC_W0: if (mem_gnt) begin
          sw0 <= mem_rdata;
          if (!rd_own) begin
            if (in_req) begin
              close_pend <= 1'b1;
              state      <= ST_DST_W0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (in_req && rd_fs) begin
            close_pend <= 1'b1;
            state      <= ST_DST_W0;
          end else begin
            state <= ST_SRC_LEN;
          end
        end
        ST_SRC_LEN: if (mem_gnt) begin
          if (!rd_len_ok) begin
            in_req <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            slen  <= mem_rdata;
            state <= ST_SRC_ADR;
          end
        end
        ST_SRC_ADR: if (mem_gnt) begin
          sadr  <= mem_rdata;
          state <= ST_SRC_DP;
        end
        ST_SRC_DP: if (dp_ready) state <= ST_SRC_CLR;
        ST_SRC_CLR: if (mem_gnt) begin
          in_req <= 1'b1;
          state  <= ST_SRC_W0;
        end
        ST_DST_W0: if (mem_gnt) begin
          if (!rd_own) begin
            state <= ST_IDLE;
          end else begin
            dw0   <= mem_rdata;
            state <= ST_DST_FIN;
          end
        end
        ST_DST_FIN: if (dp_fin_ack) state <= ST_DST_CLR;
        ST_DST_CLR: if (mem_gnt) begin
          in_req     <= 1'b0;
          close_pend <= 1'b0;
          state      <= ST_SRC_W0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import rfc_pkg::*;
#(
  parameter int MAX_LEN    = 8192,
  parameter int SRC_STRIDE = 16,
  parameter int DST_STRIDE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        dp_valid,
  output logic        dp_first,
  output logic [31:0] dp_addr,
  output logic [31:0] dp_len,
  input  logic        dp_ready,
  output logic        dp_fin,
  input  logic        dp_fin_ack,
  input  logic        dp_buf_flag,
  output logic        irq,
  output logic        busy
);

  localparam int NRING = 2;

  logic [PEND_W-1:0] ev_set;
  logic [PEND_W-1:0] pend;
  logic              kick, sreset;
  logic              ev_sdu, ev_sdl;

  logic [WORD_W-1:0] ring_base [NRING];
  logic [WORD_W-1:0] ring_lval [NRING];
  logic [WORD_W-1:0] ring_ptr  [NRING];
  logic              ring_load [NRING];
  logic              ring_adv  [NRING];
  logic              ring_eor  [NRING];

  assign ev_sdu = ev_set[P_SRC_UNAV];
  assign ev_sdl = ev_set[P_SRC_LEN];

  rfc_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ev_set       (ev_set),
    .src_base     (ring_base[0]),
    .dst_base     (ring_base[1]),
    .src_load     (ring_load[0]),
    .src_load_val (ring_lval[0]),
    .dst_load     (ring_load[1]),
    .dst_load_val (ring_lval[1]),
    .kick         (kick),
    .sreset       (sreset),
    .pend         (pend),
    .irq          (irq)
  );

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    rfc_ring_ptr #(
      .STRIDE ((g == 0) ? SRC_STRIDE : DST_STRIDE)
    ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ring_load[g]),
      .load_val (ring_lval[g]),
      .advance  (ring_adv[g]),
      .eor      (ring_eor[g]),
      .base     (ring_base[g]),
      .ptr      (ring_ptr[g])
    );
  end

  rfc_walker #(
    .MAX_LEN (MAX_LEN)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick        (kick),
    .sreset      (sreset),
    .src_ptr     (ring_ptr[0]),
    .dst_ptr     (ring_ptr[1]),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_gnt     (mem_gnt),
    .mem_rdata   (mem_rdata),
    .dp_valid    (dp_valid),
    .dp_first    (dp_first),
    .dp_addr     (dp_addr),
    .dp_len      (dp_len),
    .dp_ready    (dp_ready),
    .dp_fin      (dp_fin),
    .dp_fin_ack  (dp_fin_ack),
    .dp_buf_flag (dp_buf_flag),
    .src_adv     (ring_adv[0]),
    .src_eor     (ring_eor[0]),
    .dst_adv     (ring_adv[1]),
    .dst_eor     (ring_eor[1]),
    .ev_set      (ev_set),
    .busy        (busy)
  );

endmodule

// File: rtl/desc_ring_ctrl_chk.sv
module desc_ring_ctrl_chk #(
  parameter int MAX_LEN = 8192
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        dp_valid,
  input logic [31:0] dp_len,
  input logic        busy,
  input logic        ev_sdu,
  input logic        ev_sdl,
  input logic        sreset,
  input logic [4:0]  pend
);

  // Every write-back hands the descriptor back to software.
  assert_wb_own_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  // The datapath never sees a length outside the legal window.
  assert_len_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid |-> ((dp_len != 32'd0) && (dp_len <= 32'(MAX_LEN))));

  // A walk only begins after a kick write to the command register.
  assert_kick_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_addr == 4'h8) && reg_wdata[1]));

  // An unowned source outside a request latches bit 15 and idles.
  assert_src_unav_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sdu && !sreset) |=> (pend[4] && !busy));

  // A bad length latches bit 14 and idles.
  assert_len_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sdl && !sreset) |=> (pend[3] && !busy));

  // Soft reset empties status and stops the walk.
  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> ((pend == 5'd0) && !busy));

endmodule

bind desc_ring_ctrl desc_ring_ctrl_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .dp_valid  (dp_valid),
  .dp_len    (dp_len),
  .busy      (busy),
  .ev_sdu    (ev_sdu),
  .ev_sdl    (ev_sdl),
  .sreset    (sreset),
  .pend      (pend)
);

// File: tb/desc_ring_ctrl_bench.sv
module desc_ring_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dp_valid, dp_first, dp_ready, dp_fin, dp_fin_ack, dp_buf_flag;
  logic [31:0] dp_addr, dp_len;
  logic        irq, busy;
  logic        buf_flag = 1'b0;

  always #5 clk = ~clk;

  desc_ring_ctrl u_desc_ring_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dp_valid(dp_valid), .dp_first(dp_first), .dp_addr(dp_addr), .dp_len(dp_len),
    .dp_ready(dp_ready), .dp_fin(dp_fin), .dp_fin_ack(dp_fin_ack), .dp_buf_flag(dp_buf_flag),
    .irq(irq), .busy(busy)
  );

  // Memory: zero-wait responder; host writes go through the same process.
  logic [31:0] mem [0:255];
  logic        hw_en = 1'b0;
  logic [7:0]  hw_idx = 8'h0;
  logic [31:0] hw_val = 32'h0;

  assign mem_gnt     = mem_req;
  assign mem_rdata   = mem[mem_addr[9:2]];
  assign dp_ready    = dp_valid;
  assign dp_fin_ack  = dp_fin;
  assign dp_buf_flag = buf_flag;

  always @(posedge clk) begin
    if (hw_en) mem[hw_idx] <= hw_val;
    else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  // Reference model state
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] emem [0:255];
  int          m_sbase, m_dbase, m_sp, m_dp;
  logic [4:0]  m_pend, m_en;
  bit          m_cke, m_inreq, m_close;
  logic [31:0] q_addr [$];
  logic [31:0] q_len  [$];
  bit          q_first [$];

  localparam int SRC_B = 32'h100;
  localparam int DST_B = 32'h200;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of the walk, restated from the requirements.
  task automatic model_walk();
    logic [31:0] w, len;
    int i;
    for (int g = 0; g < 64; g++) begin
      if (!m_close) begin
        i = (m_sp >> 2) & 255;
        w = emem[i];
        if (!w[31]) begin
          if (m_inreq) m_close = 1;
          else begin m_pend[4] = 1'b1; return; end
        end else if (m_inreq && w[29]) begin
          m_close = 1;
        end else begin
          len = emem[i + 1];
          if (len == 0 || len > 8192) begin
            m_pend[3] = 1'b1; m_inreq = 0; return;
          end
          q_addr.push_back(emem[i + 3]);
          q_len.push_back(len);
          q_first.push_back(!m_inreq);
          emem[i] = w & 32'h7FFF_FFFF;
          m_sp = w[30] ? m_sbase : m_sp + 16;
          m_inreq = 1;
          continue;
        end
      end
      i = (m_dp >> 2) & 255;
      w = emem[i];
      if (!w[31]) begin m_pend[2] = 1'b1; return; end
      if (buf_flag) m_pend[0] = 1'b1;
      emem[i] = w & 32'h7FFF_FFFF;
      m_pend[1] = 1'b1;
      m_dp = w[30] ? m_dbase : m_dp + 32;
      m_inreq = 0;
      m_close = 0;
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      4'h0: begin m_sbase = d; m_sp = d; end
      4'h4: begin m_dbase = d; m_dp = d; end
      4'hC: begin m_en = d[15:11]; m_cke = d[6]; end
      4'h8: begin
        if (d[0]) begin
          m_pend = '0; m_sp = m_sbase; m_dp = m_dbase; m_inreq = 0; m_close = 0;
        end else begin
          m_pend = m_pend & ~d[15:11];
          if (d[1] && m_cke) model_walk();
        end
      end
      default: ;
    endcase
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic host_mem(input int idx, input logic [31:0] v);
    @(negedge clk);
    hw_en = 1'b1; hw_idx = idx[7:0]; hw_val = v;
    @(negedge clk);
    hw_en = 1'b0;
    emem[idx] = v;
  endtask

  // flags: {own, eor, fs}
  task automatic put_src(input int n, input logic [2:0] f, input int len, input int adr);
    int b;
    b = (SRC_B >> 2) + 4 * n;
    host_mem(b, {f, 29'h0480_0000 | 29'(n)});
    host_mem(b + 1, len);
    host_mem(b + 2, 32'h0);
    host_mem(b + 3, adr);
  endtask

  task automatic put_dst(input int n, input logic own, input logic eor);
    host_mem((DST_B >> 2) + 8 * n, {own, eor, 30'h0000_0C00 | 30'(n)});
  endtask

  task automatic run_kick(input logic [31:0] extra);
    int t;
    reg_wr(4'h8, 32'h2 | extra);
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    if (busy) check("R3 walk did not return to idle", 1, 0);
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    int bad;
    reg_rd(4'h8, v);
    check({req, " status"}, v, {16'h0, m_pend, 11'h0});
    check({req, " irq"}, {31'h0, irq}, {31'h0, |(m_pend & m_en)});
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
    check({req, " memory image mismatches"}, bad, 0);
    check({req, " datapath transfers outstanding"}, q_addr.size(), 0);
  endtask

  // Per-clock comparison of datapath transfers against the model queue.
  always @(negedge clk) begin
    if (rst_n && dp_valid && dp_ready) begin
      if (q_addr.size() == 0) begin
        check("R5 unexpected datapath transfer", 1, 0);
      end else begin
        check("R5 transfer address", dp_addr, q_addr.pop_front());
        check("R5 transfer length", dp_len, q_len.pop_front());
        check("R5 transfer first flag", {31'h0, dp_first}, {31'h0, q_first.pop_front()});
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin mem[i] = 32'h0; emem[i] = 32'h0; end
    m_sbase = 0; m_dbase = 0; m_sp = 0; m_dp = 0; m_pend = '0; m_en = '0;
    m_cke = 0; m_inreq = 0; m_close = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq in reset", {31'h0, irq}, 0);
    check("R1 busy in reset", {31'h0, busy}, 0);
    check("R1 mem_req in reset", {31'h0, mem_req}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a += 4) begin
      reg_rd(4'(a), v);
      check("R1 register after reset", v, 0);
    end

    // R2: map and control mask
    reg_wr(4'hC, 32'hFFFF_FFFF);
    reg_rd(4'hC, v);
    check("R2 control writable bits", v, 32'h0000_F9FF);
    reg_wr(4'h0, SRC_B);
    reg_wr(4'h4, DST_B);
    reg_rd(4'h0, v); check("R2 source base", v, SRC_B);
    reg_rd(4'h4, v); check("R2 destination base", v, DST_B);
    reg_wr(4'hC, 32'h0000_F800);

    // Two requests: {src0, src1} and {src2}; src3 unowned.
    put_src(0, 3'b101, 100, 32'hA000_0000);
    put_src(1, 3'b100, 200, 32'hA000_1000);
    put_src(2, 3'b101, 64,  32'hA000_2000);
    put_src(3, 3'b000, 16,  32'hA000_3000);
    put_dst(0, 1, 0);
    put_dst(1, 1, 0);

    // R3: kick ignored with clock enable clear
    run_kick(0);
    repeat (3) @(negedge clk);
    check("R3 no walk without clock enable", {31'h0, busy}, 0);
    check_state("R3 kick ignored");

    reg_wr(4'hC, 32'h0000_F840);
    run_kick(0);
    check_state("R4 R5 R6 two requests");

    // R11: write-1-to-clear
    reg_wr(4'h8, 32'h0000_9000);
    check_state("R11 clear pending");

    // R9: zero length, then over-limit length, masked interrupt
    put_src(3, 3'b101, 0, 32'hB000_0000);
    reg_wr(4'hC, 32'h0000_2040);
    run_kick(0);
    check_state("R9 zero length, R11 masked irq");
    reg_wr(4'hC, 32'h0000_F840);
    check("R11 irq with enable", {31'h0, irq}, 1);
    reg_wr(4'h8, 32'h0000_4000);
    put_src(3, 3'b101, 8193, 32'hB000_0000);
    run_kick(0);
    check_state("R9 length 8193");
    reg_wr(4'h8, 32'h0000_4000);

    // R9 boundary 8192 accepted; R10 destination unavailable then resume
    put_src(3, 3'b101, 8192, 32'hB000_4000);
    put_dst(2, 0, 0);
    run_kick(0);
    check_state("R10 destination unavailable");
    reg_wr(4'h8, 32'h0000_F800);
    put_dst(2, 1, 0);
    run_kick(0);
    check_state("R10 resumed close");
    reg_wr(4'h8, 32'h0000_F800);

    // R7: end-of-ring on both rings; R13 buffer flag
    buf_flag = 1'b1;
    put_src(4, 3'b111, 32, 32'hC000_0000);
    put_src(0, 3'b101, 48, 32'hC000_1000);
    put_dst(3, 1, 1);
    put_dst(0, 1, 0);
    run_kick(0);
    check_state("R7 R13 ring wrap with buffer flag");
    buf_flag = 1'b0;

    // R12: soft reset returns pointers to base
    put_src(1, 3'b101, 16, 32'hD000_1000);
    reg_wr(4'h8, 32'h0000_0001);
    check_state("R12 soft reset clears status");
    put_src(0, 3'b101, 20, 32'hD000_0000);
    put_dst(0, 1, 0);
    put_dst(1, 1, 0);
    run_kick(0);
    check_state("R12 walk restarts at base");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule